// File: doc/BRIEF.md
# Four-Channel Serial Audio Port

This block is the master side of a serial audio link. From the internal master clock it generates a bit clock, a word select and a master clock output at 256 times the sample rate. It shifts out two stereo data lines, which carry four output channels, and it shifts in one stereo line. One frame lasts 64 bit clocks. Each bit clock lasts `BCLK_DIV` master clocks, so with the defaults a frame is 1024 master clocks and the sample rate is the master clock divided by 1024.

On the parallel side, the block takes four output samples of `OUT_W` bits once per frame and returns two input samples of `IN_W` bits once per frame, flagged by a one-cycle valid pulse. A format input selects where the sample sits within each 32-bit half-frame. In I2S framing the MSB follows the word-select change by one bit. In right-justified framing the LSB is the last bit before the change. The block samples this format input only at frame boundaries, and the chosen format applies to the outputs and to the input alike.

Top module: `quad_audio_serial_port`

## Requirements
- R1: A frame lasts 64 bit clocks of `BCLK_DIV` master clocks each. `sck_o` is low for the first half of each bit period and high for the second half, counted from reset release. `rx_valid_o` pulses once every 64*`BCLK_DIV` cycles, in the first cycle of a frame.
- R2: `mclk_o` is the master clock divided by 4 (256 times the sample rate) with a 50 % duty cycle. It rises after the second master clock edge following reset release.
- R3: `ws_o` is low during bit slots 0 to 31 of a frame (left) and high during slots 32 to 63 (right). `ws_o` and `sd_o` change only together with a falling `sck_o`.
- R4: With `fmt_rj_i` = 0 (I2S framing), position p of a half-frame (0..31) carries sample bit `OUT_W`-p for p from 1 to `OUT_W`, MSB first, and carries 0 at every other position.
- R5: With `fmt_rj_i` = 1 (right-justified framing), position p carries sample bit 31-p for p at or above 32-`OUT_W`, so the LSB sits at position 31. The leading positions carry 0.
- R6: `tx_samples_i` holds line n's left sample at bits [(2n)*`OUT_W` +: `OUT_W`] and its right sample at [(2n+1)*`OUT_W` +: `OUT_W`]. The block captures this value on the clock edge where `rx_valid_o` rises and sends it during the frame that starts there. Changes to the input during a frame have no effect on that frame.
- R7: The block captures `fmt_rj_i` on the same frame-boundary edge, and the captured value governs the whole frame for both output and input. A change during a frame takes effect only at the next boundary.
- R8: The block samples `sd_i` on the rising `sck_o`. In I2S framing, positions 1 to `IN_W` carry input bits MSB first. In right-justified framing, positions 32-`IN_W` to 31 carry them. Input bits at all other positions are ignored.
- R9: The input samples received during a frame appear on `rx_left_o` and `rx_right_o` at the next frame boundary, together with a single-cycle `rx_valid_o`. Between pulses they hold their value.
- R10: During reset, every output is 0. The first frame after reset sends all-zero samples in I2S framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_rj_i | input | 1 | Framing select: 0 I2S, 1 right-justified |
| tx_samples_i | input | LINES*2*OUT_W | Output samples, line-major, left then right |
| sd_i | input | 1 | Serial input data line |
| sck_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select, low for left |
| sd_o | output | LINES | Serial output data lines |
| mclk_o | output | 1 | Master clock output at 256 times the sample rate |
| rx_left_o | output | IN_W | Received left sample |
| rx_right_o | output | IN_W | Received right sample |
| rx_valid_o | output | 1 | One-cycle strobe: new received samples |

## Verification
The bench builds the block with its defaults: a bit clock of 16 master clocks, 20-bit outputs on two lines and a 16-bit input. With these values the two framings differ in a visible way. I2S leaves 11 trailing zero positions per half, and right-justified leaves 12 leading zeros on output and 16 on input. Both output lines have to be mapped to distinct sample fields. The bench also fills the ignored input positions with random bits. It changes the samples and the format right after each boundary, so that a design which fails to latch them at the frame boundary produces wrong bits in that same frame.

// File: rtl/sap_pkg.sv
package sap_pkg;

  localparam int HALF_BITS = 32;
  localparam int POS_W     = 5;
  localparam int SLOT_W    = 6;

  typedef enum logic {
    FMT_I2S = 1'b0,
    FMT_RJ  = 1'b1
  } fmt_e;

  typedef struct packed {
    logic             hit;
    logic [POS_W-1:0] idx;
  } slot_map_t;

  // Maps a position inside a half-frame to a sample bit index.
  function automatic slot_map_t map_slot(input fmt_e fmt,
                                         input logic [POS_W-1:0] pos,
                                         input int unsigned width);
    slot_map_t   m;
    int unsigned p;
    p     = 32'(pos);
    m.hit = 1'b0;
    m.idx = '0;
    if (fmt == FMT_I2S) begin
      if (p >= 1 && p <= width) begin
        m.hit = 1'b1;
        m.idx = POS_W'(width - p);
      end
    end else begin
      if (p >= HALF_BITS - width) begin
        m.hit = 1'b1;
        m.idx = POS_W'(HALF_BITS - 1 - p);
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/sap_timing.sv
module sap_timing
  import sap_pkg::*;
#(
  parameter int BCLK_DIV = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fmt_e              fmt_i,
  output logic              sck_o,
  output logic              ws_o,
  output logic              mclk_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [SLOT_W-1:0] slot_next_o,
  output logic              fall_o,
  output logic              rise_o,
  output logic              frame_end_o,
  output fmt_e              fmt_o
);

  localparam int PH_W = $clog2(BCLK_DIV);

  logic [PH_W-1:0]   phase_q, phase_d;
  logic [SLOT_W-1:0] slot_q, slot_d, slot_inc;
  logic              sck_q, sck_d;
  logic              ws_q, ws_d;
  logic [1:0]        mdiv_q, mdiv_d;
  fmt_e              fmt_q, fmt_d;
  logic              fall, rise, frame_end;

  always_comb begin
    fall      = (phase_q == PH_W'(BCLK_DIV - 1));
    rise      = (phase_q == PH_W'(BCLK_DIV / 2 - 1));
    slot_inc  = slot_q + SLOT_W'(1);
    frame_end = fall && (slot_q == {SLOT_W{1'b1}});

    phase_d = fall ? '0 : phase_q + PH_W'(1);
    slot_d  = fall ? slot_inc : slot_q;
    sck_d   = sck_q;
    if (fall)      sck_d = 1'b0;
    else if (rise) sck_d = 1'b1;
    ws_d    = fall ? slot_inc[SLOT_W-1] : ws_q;
    fmt_d   = frame_end ? fmt_i : fmt_q;
    mdiv_d  = mdiv_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      slot_q  <= '0;
      sck_q   <= 1'b0;
      ws_q    <= 1'b0;
      mdiv_q  <= '0;
      fmt_q   <= FMT_I2S;
    end else begin
      phase_q <= phase_d;
      slot_q  <= slot_d;
      sck_q   <= sck_d;
      ws_q    <= ws_d;
      mdiv_q  <= mdiv_d;
      fmt_q   <= fmt_d;
    end
  end

  assign sck_o       = sck_q;
  assign ws_o        = ws_q;
  assign mclk_o      = mdiv_q[1];
  assign slot_o      = slot_q;
  assign slot_next_o = slot_inc;
  assign fall_o      = fall;
  assign rise_o      = rise;
  assign frame_end_o = frame_end;
  assign fmt_o       = fmt_q;

endmodule

// File: rtl/sap_tx_lane.sv
module sap_tx_lane
  import sap_pkg::*;
#(
  parameter int OUT_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_i,
  input  logic              frame_end_i,
  input  logic [SLOT_W-1:0] slot_next_i,
  input  fmt_e              fmt_i,
  input  logic [OUT_W-1:0]  left_i,
  input  logic [OUT_W-1:0]  right_i,
  output logic              sd_o
);

  localparam int IDX_W = $clog2(OUT_W);

  logic [OUT_W-1:0] hold_l_q, hold_l_d;
  logic [OUT_W-1:0] hold_r_q, hold_r_d;
  logic [OUT_W-1:0] src;
  logic             sd_q, sd_d, bit_val;
  slot_map_t        m;

  always_comb begin
    m        = map_slot(fmt_i, slot_next_i[POS_W-1:0], OUT_W);
    src      = slot_next_i[SLOT_W-1] ? hold_r_q : hold_l_q;
    bit_val  = m.hit ? src[IDX_W'(m.idx)] : 1'b0;
    hold_l_d = frame_end_i ? left_i  : hold_l_q;
    hold_r_d = frame_end_i ? right_i : hold_r_q;
    sd_d     = fall_i ? bit_val : sd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l_q <= '0;
      hold_r_q <= '0;
      sd_q     <= 1'b0;
    end else begin
      hold_l_q <= hold_l_d;
      hold_r_q <= hold_r_d;
      sd_q     <= sd_d;
    end
  end

  assign sd_o = sd_q;

endmodule

// File: rtl/sap_rx_lane.sv
module sap_rx_lane
  import sap_pkg::*;
#(
  parameter int IN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_i,
  input  logic              frame_end_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  fmt_e              fmt_i,
  input  logic              sd_i,
  output logic [IN_W-1:0]   left_o,
  output logic [IN_W-1:0]   right_o,
  output logic              valid_o
);

  localparam int IDX_W = $clog2(IN_W);

  logic [IN_W-1:0] acc_l_q, acc_l_d;
  logic [IN_W-1:0] acc_r_q, acc_r_d;
  logic [IN_W-1:0] out_l_q, out_l_d;
  logic [IN_W-1:0] out_r_q, out_r_d;
  logic            valid_q, valid_d;
  logic            take;
  slot_map_t       m;

  always_comb begin
    m       = map_slot(fmt_i, slot_i[POS_W-1:0], IN_W);
    take    = rise_i && m.hit;
    acc_l_d = acc_l_q;
    acc_r_d = acc_r_q;
    if (take && !slot_i[SLOT_W-1]) acc_l_d[IDX_W'(m.idx)] = sd_i;
    if (take &&  slot_i[SLOT_W-1]) acc_r_d[IDX_W'(m.idx)] = sd_i;
    out_l_d = frame_end_i ? acc_l_q : out_l_q;
    out_r_d = frame_end_i ? acc_r_q : out_r_q;
    valid_d = frame_end_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_l_q <= '0;
      acc_r_q <= '0;
      out_l_q <= '0;
      out_r_q <= '0;
      valid_q <= 1'b0;
    end else begin
      acc_l_q <= acc_l_d;
      acc_r_q <= acc_r_d;
      out_l_q <= out_l_d;
      out_r_q <= out_r_d;
      valid_q <= valid_d;
    end
  end

  assign left_o  = out_l_q;
  assign right_o = out_r_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/quad_audio_serial_port.sv
module quad_audio_serial_port
  import sap_pkg::*;
#(
  parameter int BCLK_DIV = 16,
  parameter int OUT_W    = 20,
  parameter int IN_W     = 16,
  parameter int LINES    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fmt_rj_i,
  input  logic [LINES*2*OUT_W-1:0] tx_samples_i,
  input  logic                     sd_i,
  output logic                     sck_o,
  output logic                     ws_o,
  output logic [LINES-1:0]         sd_o,
  output logic                     mclk_o,
  output logic [IN_W-1:0]          rx_left_o,
  output logic [IN_W-1:0]          rx_right_o,
  output logic                     rx_valid_o
);

  logic [SLOT_W-1:0] slot, slot_next;
  logic              fall, rise, frame_end;
  fmt_e              fmt_frame;

  sap_timing #(.BCLK_DIV(BCLK_DIV)) u_timing (
    .clk         (clk),
    .rst_n       (rst_n),
    .fmt_i       (fmt_e'(fmt_rj_i)),
    .sck_o       (sck_o),
    .ws_o        (ws_o),
    .mclk_o      (mclk_o),
    .slot_o      (slot),
    .slot_next_o (slot_next),
    .fall_o      (fall),
    .rise_o      (rise),
    .frame_end_o (frame_end),
    .fmt_o       (fmt_frame)
  );

  for (genvar ln = 0; ln < LINES; ln++) begin : g_line
    sap_tx_lane #(.OUT_W(OUT_W)) u_tx (
      .clk         (clk),
      .rst_n       (rst_n),
      .fall_i      (fall),
      .frame_end_i (frame_end),
      .slot_next_i (slot_next),
      .fmt_i       (fmt_frame),
      .left_i      (tx_samples_i[(2*ln)*OUT_W +: OUT_W]),
      .right_i     (tx_samples_i[(2*ln+1)*OUT_W +: OUT_W]),
      .sd_o        (sd_o[ln])
    );
  end

  sap_rx_lane #(.IN_W(IN_W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise_i      (rise),
    .frame_end_i (frame_end),
    .slot_i      (slot),
    .fmt_i       (fmt_frame),
    .sd_i        (sd_i),
    .left_o      (rx_left_o),
    .right_o     (rx_right_o),
    .valid_o     (rx_valid_o)
  );

endmodule

// File: rtl/sap_checker.sv
module sap_checker #(
  parameter int IN_W  = 16,
  parameter int LINES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sck_o,
  input logic             ws_o,
  input logic [LINES-1:0] sd_o,
  input logic             mclk_o,
  input logic [IN_W-1:0]  rx_left_o,
  input logic [IN_W-1:0]  rx_right_o,
  input logic             rx_valid_o
);

  AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(ws_o) |-> $fell(sck_o)); // R3

  AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(sd_o) |-> $fell(sck_o)); // R3

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o); // R9

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid_o |-> ($stable(rx_left_o) && $stable(rx_right_o))); // R9

  AST_MCLK_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(mclk_o) |=> $stable(mclk_o)); // R2

  AST_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid_o) |-> (!ws_o && !sck_o)); // R1

endmodule

bind quad_audio_serial_port sap_checker #(.IN_W(IN_W), .LINES(LINES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sck_o      (sck_o),
  .ws_o       (ws_o),
  .sd_o       (sd_o),
  .mclk_o     (mclk_o),
  .rx_left_o  (rx_left_o),
  .rx_right_o (rx_right_o),
  .rx_valid_o (rx_valid_o)
);

// File: tb/quad_audio_serial_port_tb.sv
`timescale 1ns/1ps
module quad_audio_serial_port_tb;

  localparam int DIV    = 16;
  localparam int OUT_W  = 20;
  localparam int IN_W   = 16;
  localparam int LINES  = 2;
  localparam int FRAMES = 40;

  logic                     clk;
  logic                     rst_n;
  logic                     fmt_rj_i;
  logic [LINES*2*OUT_W-1:0] tx_samples_i;
  logic                     sd_i;
  logic                     sck_o, ws_o, mclk_o, rx_valid_o;
  logic [LINES-1:0]         sd_o;
  logic [IN_W-1:0]          rx_left_o, rx_right_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  quad_audio_serial_port #(.BCLK_DIV(DIV), .OUT_W(OUT_W), .IN_W(IN_W), .LINES(LINES)) u_dut (
    .clk(clk), .rst_n(rst_n), .fmt_rj_i(fmt_rj_i), .tx_samples_i(tx_samples_i),
    .sd_i(sd_i), .sck_o(sck_o), .ws_o(ws_o), .sd_o(sd_o), .mclk_o(mclk_o),
    .rx_left_o(rx_left_o), .rx_right_o(rx_right_o), .rx_valid_o(rx_valid_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit tx_exp(input bit rj, input int p, input logic [OUT_W-1:0] s);
    if (!rj) return (p >= 1 && p <= OUT_W) ? s[OUT_W-p] : 1'b0;
    return (p >= 32 - OUT_W) ? s[31-p] : 1'b0;
  endfunction

  function automatic int rx_pos_idx(input bit rj, input int p);
    if (!rj) return (p >= 1 && p <= IN_W) ? IN_W - p : -1;
    return (p >= 32 - IN_W) ? 31 - p : -1;
  endfunction

  // Stimulus for the frame after the one just started
  task automatic next_stim(input int f);
    logic [OUT_W-1:0] a, b;
    case (f)
      0: begin fmt_rj_i = 1'b0; a = '1; b = '1; end
      1: begin fmt_rj_i = 1'b1; a = '1; b = '1; end
      2: begin fmt_rj_i = 1'b1; a = 20'h80000; b = 20'h00001; end
      3: begin fmt_rj_i = 1'b0; a = 20'h80000; b = 20'h00001; end
      4: begin fmt_rj_i = 1'b0; a = 20'hAAAAA; b = 20'h55555; end
      default: begin
        fmt_rj_i = 1'($urandom);
        a = OUT_W'($urandom);
        b = OUT_W'($urandom);
      end
    endcase
    for (int i = 0; i < LINES * 2; i++) begin
      tx_samples_i[i*OUT_W +: OUT_W] = (i % 2 == 0) ? a ^ OUT_W'(i * 20'h11111) : b ^ OUT_W'(i);
      if (f >= 5) tx_samples_i[i*OUT_W +: OUT_W] = OUT_W'($urandom);
    end
  endtask

  // Watchdog
  initial begin
    #(100000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit                   cur_rj;
    logic [LINES*2*OUT_W-1:0] cur_tx;
    logic [IN_W-1:0]      cur_rxl, cur_rxr;
    logic [LINES-1:0]     cap [64];
    int unsigned          n;
    int                   rises, frames, k, p, ix;
    logic                 sck_prev;
    logic [31:0]          act_v, exp_v;

    void'($urandom(32'h5A17C3E1));
    rst_n = 1'b0;
    fmt_rj_i = 1'b0;
    sd_i = 1'b0;
    tx_samples_i = '0;
    repeat (4) @(negedge clk);
    // R10: reset values
    chk(sck_o == 0 && ws_o == 0 && sd_o == 0 && mclk_o == 0, "R10 reset serial outputs",
        {sck_o, ws_o, sd_o, mclk_o}, 0);
    chk(rx_valid_o == 0 && rx_left_o == 0 && rx_right_o == 0, "R10 reset parallel outputs",
        {rx_valid_o, rx_left_o, rx_right_o}, 0);

    cur_rj  = 1'b0;
    cur_tx  = '0;
    cur_rxl = 16'h8001;
    cur_rxr = 16'hFFFF;
    next_stim(0);
    n = 0; rises = 0; frames = 0; sck_prev = 1'b0;
    rst_n = 1'b1;

    while (frames < FRAMES) begin
      @(negedge clk);
      n++;
      chk(sck_o == ((n % DIV) >= DIV / 2), "R1 bit clock phase", sck_o, (n % DIV) >= DIV / 2);
      chk(mclk_o == ((n >> 1) & 1), "R2 master clock output", mclk_o, (n >> 1) & 1);
      chk(ws_o == (((n / DIV) % 64) >= 32), "R3 word select slot", ws_o, ((n / DIV) % 64) >= 32);
      chk(rx_valid_o == (n % (64 * DIV) == 0), "R1 frame strobe period", rx_valid_o,
          n % (64 * DIV) == 0);

      if (rx_valid_o) begin
        chk(rx_left_o == cur_rxl,  cur_rj ? "R8 R9 rx left rj"  : "R8 R9 rx left i2s",
            rx_left_o, cur_rxl);
        chk(rx_right_o == cur_rxr, cur_rj ? "R8 R9 rx right rj" : "R8 R9 rx right i2s",
            rx_right_o, cur_rxr);
        // R6 R7: values present at this edge govern the frame starting now
        cur_rj  = fmt_rj_i;
        cur_tx  = tx_samples_i;
        cur_rxl = (frames % 7 == 2) ? 16'h0001 : IN_W'($urandom);
        cur_rxr = (frames % 7 == 3) ? 16'h8000 : IN_W'($urandom);
        frames++;
        next_stim(frames);
      end

      if (sck_o && !sck_prev) begin
        k = rises % 64;
        cap[k] = sd_o;
        rises++;
        if (k == 63) begin
          for (int ln = 0; ln < LINES; ln++) begin
            for (int h = 0; h < 2; h++) begin
              for (int q = 0; q < 32; q++) begin
                act_v[31-q] = cap[h*32+q][ln];
                exp_v[31-q] = tx_exp(cur_rj, q, cur_tx[(2*ln+h)*OUT_W +: OUT_W]);
              end
              chk(act_v == exp_v, cur_rj ? "R5 R6 R7 R10 rj line half" : "R4 R6 R7 R10 i2s line half",
                  act_v, exp_v);
            end
          end
        end
      end else if (!sck_o && sck_prev) begin
        k  = rises % 64;
        p  = k % 32;
        ix = rx_pos_idx(cur_rj, p);
        if (ix < 0) sd_i = 1'($urandom);  // R8: ignored positions get noise
        else        sd_i = (k >= 32) ? cur_rxr[ix] : cur_rxl[ix];
      end
      sck_prev = sck_o;
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule